// File: doc/BRIEF.md
# PLL Automatic Holdover Controller

This controller decides when a PLL charge pump is forced into a high-impedance holdover state so that the VCO keeps its last tuning while the reference clock is missing. It contains a lock-delay counter that turns a per-cycle phase-window indication into a digital lock-detect flag. It also watches a lock-detect pin level, a PLL enable and a reference-edge strobe from the phase detector. Holdover is armed only after lock has been achieved. It triggers when that lock is lost, and it ends on the first reference edge that returns.

After release, the controller re-qualifies lock before holdover can trigger again. The lock-delay counter must see a programmable run of consecutive in-window comparison cycles, from 5 to 255. A lock-detect flag that chatters during reacquisition is passed through unfiltered, so it can retrigger holdover. Configuration (pin gating bit and delay count) arrives on plain input ports. Each clock is one phase comparison cycle.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cp_hiz` and `hold_active` are 0 and `lock_det` is 0.
- R2: While `pll_en` is 0 the controller is idle: one clock after `pll_en` is 0, `cp_hiz` is 0 and `lock_det` is 0, whatever the other inputs do. This also holds when `pll_en` drops during holdover.
- R3: `lock_det` goes to 1 after N consecutive clocks with `in_window`=1, where N is `lock_cnt` (8 bits), and N is taken as 5 when `lock_cnt` is below 5. Any clock with `in_window`=0 clears the run, and `lock_det` is 0 in the following cycle.
- R4: Lock is armed once `lock_det` has been 1 with `pll_en`=1. If `lock_det` is 0 while armed and the pin qualifies, `cp_hiz` is 1 from the next clock.
- R5: When `ld_pin_use` is 0, the `ld_pin` level is ignored and treated as 1 for entry.
- R6: When `ld_pin_use` is 1 and `ld_pin` is 0 at the moment lock is lost, holdover is not entered. The controller then waits for `lock_det` to return before it is armed again.
- R7: `cp_hiz` stays 1 while no `ref_edge` is seen. A clock with `ref_edge`=1 makes `cp_hiz` 0 from the next clock.
- R8: After release, a lock loss does not trigger holdover until `lock_det` has been 1 again.
- R9: A `lock_det` that returns high and then drops again during reacquisition retriggers holdover with no filtering.
- R10: `hold_active` is 1 exactly when `cp_hiz` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase comparison per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | PLL enable; 0 forces idle |
| in_window | input | 1 | Phase difference inside the lock window this cycle |
| ref_edge | input | 1 | Reference edge seen at the phase detector this cycle |
| ld_pin | input | 1 | Lock-detect pin level |
| ld_pin_use | input | 1 | 1: pin level gates entry; 0: pin treated as high |
| lock_cnt | input | 8 | Required in-window run length (clamped to at least 5) |
| lock_det | output | 1 | Digital lock detect from the delay counter |
| cp_hiz | output | 1 | Charge pump forced to high impedance |
| hold_active | output | 1 | Holdover status |

## Verification
The embedded assertions check on every cycle that a disabled PLL releases the charge pump and clears lock detect within one clock. They also check that an out-of-window cycle clears lock detect, that holdover persists until a reference edge, and that every entry into holdover was preceded by lost lock with a qualifying pin. Other behaviours depend on history and show up only in the bench's scenarios against its cycle model. These are the clamped and long run lengths, arming only after lock, the pin gate and its bypass, no retrigger before re-lock, and chatter that retriggers.

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl #(
  parameter int CW   = 8,
  parameter int MINC = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pll_en,
  input  logic          in_window,
  input  logic          ref_edge,
  input  logic          ld_pin,
  input  logic          ld_pin_use,
  input  logic [CW-1:0] lock_cnt,
  output logic          lock_det,
  output logic          cp_hiz,
  output logic          hold_active
);

  typedef enum logic [1:0] {IDLE, ARMED, HOLD, SETTLE} st_t;

  localparam logic [CW-1:0] MINV = CW'(MINC);

  st_t           st, st_nx;
  logic [CW-1:0] run;
  logic [CW-1:0] tgt;
  logic          pin_ok;

  assign tgt      = (lock_cnt < MINV) ? MINV : lock_cnt;
  assign lock_det = (run >= tgt);
  assign pin_ok   = !ld_pin_use || ld_pin;
  assign cp_hiz      = (st == HOLD);
  assign hold_active = cp_hiz;

  always_ff @(posedge clk) begin
    if (rst || !pll_en || !in_window) run <= '0;
    else if (run < tgt)               run <= run + 1'b1;
  end

  always_comb begin
    st_nx = st;
    case (st)
      IDLE:   if (lock_det) st_nx = ARMED;
      ARMED:  if (!lock_det) st_nx = pin_ok ? HOLD : IDLE;
      HOLD:   if (ref_edge) st_nx = SETTLE;
      SETTLE: if (lock_det) st_nx = ARMED;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !pll_en) st <= IDLE;
    else                st <= st_nx;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!cp_hiz && !lock_det));

  // R2
  dis_release_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_en |=> (!cp_hiz && !lock_det));

  // R3
  win_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> !lock_det);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_hiz && !ref_edge && pll_en) |=> cp_hiz);

  // R4
  entry_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cp_hiz) |-> $past(!lock_det && pll_en && (!ld_pin_use || ld_pin)));

  // R7
  ref_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_hiz && ref_edge) |=> !cp_hiz);

endmodule

// File: tb/pll_holdover_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_holdover_ctrl_tb_top;

  logic clk = 0;
  logic rst, pll_en, in_window, ref_edge, ld_pin, ld_pin_use;
  logic [7:0] lock_cnt;
  logic lock_det, cp_hiz, hold_active;

  always #10 clk = ~clk;

  pll_holdover_ctrl dut_i (
    .clk(clk), .rst(rst), .pll_en(pll_en), .in_window(in_window),
    .ref_edge(ref_edge), .ld_pin(ld_pin), .ld_pin_use(ld_pin_use),
    .lock_cnt(lock_cnt), .lock_det(lock_det), .cp_hiz(cp_hiz),
    .hold_active(hold_active)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string req = "R1";
  int m_run = 0;
  int m_phase = 0;   // 0 wait lock, 1 armed, 2 holding, 3 resettling

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit en, input bit win, input bit rf,
                      input bit pin, input bit use_pin);
    int need;
    bit locked, qual;
    rst = r; pll_en = en; in_window = win; ref_edge = rf;
    ld_pin = pin; ld_pin_use = use_pin;
    need = (int'(lock_cnt) < 5) ? 5 : int'(lock_cnt);
    locked = (m_run >= need);
    qual = !use_pin || pin;
    @(posedge clk);
    if (r || !en) begin
      m_run = 0; m_phase = 0;
    end else begin
      if (m_phase == 0 && locked) m_phase = 1;
      else if (m_phase == 1 && !locked) m_phase = qual ? 2 : 0;
      else if (m_phase == 2 && rf) m_phase = 3;
      else if (m_phase == 3 && locked) m_phase = 1;
      if (!win) m_run = 0;
      else if (m_run < need) m_run++;
    end
    #2;
    chk(cp_hiz, m_phase == 2, "cp_hiz");
    chk(lock_det, m_run >= need, "lock_det");
    // R10
    chk(hold_active, cp_hiz, "hold_active vs cp_hiz");
  endtask

  task automatic run_win(input int n, input bit use_pin, input bit pin);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, pin, use_pin);
  endtask

  initial begin
    lock_cnt = 8'd5;
    req = "R1";
    step(1, 1, 1, 0, 1, 1);
    step(1, 1, 1, 1, 1, 1);
    step(0, 0, 0, 0, 1, 1);

    req = "R2";
    for (int i = 0; i < 15; i++) step(0, 0, 1, i % 2, 1, 0);

    req = "R3";
    lock_cnt = 8'd3;
    run_win(4, 1, 1);
    step(0, 1, 0, 0, 1, 1);
    run_win(7, 1, 1);
    step(0, 1, 0, 0, 1, 1);
    req = "R4";
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 1, 1);
    req = "R7";
    step(0, 1, 0, 1, 1, 1);
    step(0, 1, 0, 0, 1, 1);

    req = "R8";
    lock_cnt = 8'd10;
    for (int i = 0; i < 6; i++) run_win(4, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 1, i % 2, 0, 1, 1);
    run_win(12, 1, 1);

    req = "R9";
    step(0, 1, 0, 0, 1, 1);
    step(0, 1, 0, 1, 1, 1);
    run_win(10, 1, 1);
    step(0, 1, 0, 0, 1, 1);
    step(0, 1, 0, 0, 1, 1);
    step(0, 1, 0, 1, 1, 1);

    req = "R6";
    run_win(11, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 1);
    run_win(11, 1, 0);

    req = "R5";
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);

    req = "R2";
    step(0, 0, 1, 0, 1, 1);
    step(0, 0, 1, 0, 1, 1);

    req = "R3";
    lock_cnt = 8'd255;
    run_win(260, 1, 1);
    step(0, 1, 0, 0, 1, 1);
    step(0, 1, 0, 1, 1, 1);

    req = "R1";
    step(1, 1, 1, 0, 1, 1);
    step(0, 1, 1, 0, 1, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule